// File: doc/BRIEF.md
# Single-Slot Fetch-to-Execute Pipeline Register with Flush

This block is a one-deep queue between an instruction fetch stage and an execute stage. It holds one record, the address of a fetched instruction and the instruction word, and a valid flag that marks the slot as occupied. The fetch side pushes a record, the execute side pops it, and a flush input drops whatever is held, for example when a taken branch shows that the fetched instruction is on the wrong path.

Push, pop and flush may be requested in the same cycle. The combined effect is the same as doing them in a fixed order: pop first, then push, then flush. Because pop comes before push, an occupied slot that is being drained can take a new record in the same cycle, so the two stages can each do one instruction per cycle. Because flush comes last, a flush always leaves the slot empty.

The `room` output depends combinationally on `pop` in that cycle. The producer must register its push decision, or accept that path through `room`.

Top module: `fetch_pipe_reg`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `holding` is 0 and `room` is 1.
- R2: `holding` is 1 exactly when the slot holds a record. In a cycle where the slot is empty, or where it is occupied and `pop` is 1, `room` is 1. In a cycle where the slot is occupied and `pop` is 0, `room` is 0.
- R3: A pop of an occupied slot, with no push and no flush, leaves the slot empty in the next cycle. A pop of an empty slot has no effect.
- R4: A push while `room` is 1 and `flush` is 0 leaves the slot occupied in the next cycle with the pushed address and word. This includes a push in the same cycle as a pop of an occupied slot.
- R5: A flush leaves the slot empty in the next cycle, whatever push and pop do in the same cycle.
- R6: A push while the slot is occupied and neither pop nor flush is asserted is ignored. The slot stays occupied and the held address and word do not change.
- R7: While `holding` is 1, `head_pc` and `head_insn` show the held address and word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push | input | 1 | Request to load a new record |
| push_pc | input | PC_W (32) | Address of the record being pushed |
| push_insn | input | INSN_W (32) | Instruction word of the record being pushed |
| pop | input | 1 | Request to remove the held record |
| flush | input | 1 | Drop the held record and any push in this cycle |
| room | output | 1 | A push in this cycle will be accepted |
| holding | output | 1 | The slot holds a record |
| head_pc | output | PC_W (32) | Held address, valid while `holding` is 1 |
| head_insn | output | INSN_W (32) | Held instruction word, valid while `holding` is 1 |

## Verification
The bench drives every combination of push, pop and flush against both an empty slot and a full slot. Each combination targets a specific wrong ordering. A design that applied flush before push would keep a record that should have been dropped. One that ignored a same-cycle pop when computing `room` would stall a draining pipeline and lose the pushed record. One that let a push overwrite a full slot would silently replace an instruction that has not yet been executed. A pop of an empty slot is also exercised, to catch a design that corrupts its state on that request.

// File: rtl/fetch_pipe_reg.sv
module fetch_pipe_reg #(
  parameter int PC_W   = 32,
  parameter int INSN_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [PC_W-1:0]   push_pc,
  input  logic [INSN_W-1:0] push_insn,
  input  logic              pop,
  input  logic              flush,
  output logic              room,
  output logic              holding,
  output logic [PC_W-1:0]   head_pc,
  output logic [INSN_W-1:0] head_insn
);

  logic              full_q;
  logic [PC_W-1:0]   pc_q;
  logic [INSN_W-1:0] insn_q;
  logic              accept;

  assign room      = !full_q || pop;
  assign accept    = push && room;
  assign holding   = full_q;
  assign head_pc   = pc_q;
  assign head_insn = insn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      full_q <= 1'b0;
    else if (flush)  full_q <= 1'b0;
    else if (accept) full_q <= 1'b1;
    else if (pop)    full_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      pc_q   <= push_pc;
      insn_q <= push_insn;
    end
  end

  p_empty_has_room_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !holding |-> room);

  p_pop_drains_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && holding && !push && !flush) |=> !holding);

  p_push_loads_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (push && room && !flush) |=> (holding && head_pc == $past(push_pc)
                                  && head_insn == $past(push_insn)));

  p_flush_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !holding);

  p_full_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (holding && !pop && !flush) |=> (holding && $stable(head_pc) && $stable(head_insn)));

endmodule

// File: tb/fetch_pipe_reg_tb.sv
module fetch_pipe_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        push = 1'b0, pop = 1'b0, flush = 1'b0;
  logic [31:0] push_pc = '0, push_insn = '0;
  logic        room, holding;
  logic [31:0] head_pc, head_insn;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  bit          m_full = 0;
  logic [31:0] m_pc = '0, m_insn = '0;

  always #2 clk = ~clk;

  fetch_pipe_reg dut_i (
    .clk(clk), .rst_n(rst_n), .push(push), .push_pc(push_pc), .push_insn(push_insn),
    .pop(pop), .flush(flush), .room(room), .holding(holding),
    .head_pc(head_pc), .head_insn(head_insn)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    chk(holding == m_full, req, "holding", {31'b0, holding}, {31'b0, m_full});
    if (m_full) begin
      chk(head_pc == m_pc, "R7", "head_pc", head_pc, m_pc);
      chk(head_insn == m_insn, "R7", "head_insn", head_insn, m_insn);
    end
  endtask

  task automatic step(input bit e, input bit d, input bit c,
                      input logic [31:0] pc, input logic [31:0] ins, input string req);
    bit exp_room;
    @(negedge clk);
    push = e; pop = d; flush = c; push_pc = pc; push_insn = ins;
    #1;
    exp_room = !m_full || d;
    chk(room == exp_room, "R2", "room", {31'b0, room}, {31'b0, exp_room});
    @(posedge clk);
    if (c) m_full = 0;
    else if (e && exp_room) begin m_full = 1; m_pc = pc; m_insn = ins; end
    else if (d) m_full = 0;
    @(negedge clk);
    push = 0; pop = 0; flush = 0;
    check_state(req);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!holding, "R1", "holding in reset", {31'b0, holding}, 32'd0);
    chk(room, "R1", "room in reset", {31'b0, room}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!holding, "R1", "holding after reset", {31'b0, holding}, 32'd0);
    chk(room, "R1", "room after reset", {31'b0, room}, 32'd1);

    step(0, 1, 0, 32'h0, 32'h0, "R3");
    step(1, 0, 0, 32'h100, 32'hAAAA0001, "R4");
    step(1, 0, 0, 32'h104, 32'hBBBB0002, "R6");
    step(1, 0, 0, 32'h108, 32'hCCCC0003, "R6");
    step(1, 1, 0, 32'h10C, 32'hDDDD0004, "R4");
    step(0, 1, 0, 32'h0, 32'h0, "R3");
    step(1, 0, 0, 32'h200, 32'h11110005, "R4");
    step(1, 1, 1, 32'h204, 32'h22220006, "R5");
    step(1, 0, 1, 32'h208, 32'h33330007, "R5");
    step(1, 0, 0, 32'h20C, 32'h44440008, "R4");
    step(0, 0, 1, 32'h0, 32'h0, "R5");
    step(0, 1, 1, 32'h0, 32'h0, "R5");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0], r[1], (r[4:2] == 3'd0), $urandom, $urandom, "R4");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule